// File: doc/BRIEF.md
# Multi-Digit BCD Seven-Segment Decoder with Zero Suppression and Dimming

This block turns a row of 4-bit BCD digits into active-low seven-segment drives, one group of seven per digit. Each digit is handled by a combinational decoder slice with three active-low controls: a forced blank, a lamp test and a ripple-blank input. Each slice also returns an active-low ripple-blank output. The shared blanking pin of a discrete decoder is split here into a separate blank input and a separate ripple-blank output. A slice goes dark when either of them calls for it.

The wrapper chains the slices for leading-zero suppression. The most significant slice has its ripple-blank input held low. Every slice passes its ripple-blank output down to the next lower digit. The lowest digit never takes part, so a value of all zeros still shows a single 0.

Brightness is set by an 8-bit free-running counter compared against a duty input. The comparison drives the blank control of every slice. The external blank input is combined with this dimming signal.

Top module: `seg_display_top`

## Requirements
- R1: Segment bus bit 0 is segment a, and so on up to bit 6, which is segment g. A segment is lit when its bit is 0. Codes 0 to 9 light these segments: 0 a b c d e f; 1 b c; 2 a b d e g; 3 a b c d g; 4 b c f g; 5 a c d f g; 6 c d e f g; 7 a b c; 8 all seven; 9 a b c f g. Digit i uses seg_n[7i+6:7i] and bcd[4i+3:4i], and digit 0 is the least significant.
- R2: The codes above 9 light these segments: 10 d e g; 11 c d g; 12 b f g; 13 a d f g; 14 d e f g. Code 15 lights none.
- R3: When blank_n is low, or the dimming signal is in its dark phase, every segment of every digit is dark, whatever the other inputs are.
- R4: When lamp_test_n is low and no blanking applies, all segments of every digit are lit. Every ripple-blank output is then high.
- R5: A digit whose ripple-blank input is low goes dark when its code is 0 and lamp test is inactive, and its ripple-blank output then goes low. A digit with a nonzero code ignores its ripple-blank input and keeps its ripple-blank output high.
- R6: The most significant digit's ripple-blank input is held low. Each digit's ripple-blank output feeds the next lower digit. The lowest digit always shows 0 for a zero code, and rb_out_n[0] is always high.
- R7: An 8-bit counter advances by one every clock. A digit may be lit only while the counter is below duty. Over any 256 consecutive cycles the display is lit in exactly duty cycles, so a duty of 0 keeps it dark.
- R8: While rst_n is low, the counter is held at 0. With duty of 1 or more, a lit display therefore stays lit for the whole of the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the dimming counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lamp_test_n | input | 1 | Active-low lamp test, lights every segment |
| blank_n | input | 1 | Active-low forced blank for all digits |
| duty | input | 8 | Number of lit cycles in each 256-cycle dimming period |
| bcd | input | 16 | Four BCD codes, digit 0 in bits 3:0 |
| seg_n | output | 28 | Active-low segment drives, seven per digit |
| rb_out_n | output | 4 | Active-low ripple-blank output of each digit |

## Verification
The bench pays most attention to where zero suppression stops. A zero inside the number, such as the middle 0 in 102, must stay visible. Trailing zeros after a nonzero digit must stay visible. A lone 0 must stay visible. A chain that leaked its suppression past a nonzero digit would drop these digits, and a chain that never released would blank the whole display.

Priority is the second target. Lamp test applied to a zero value must light everything and raise every ripple output. Blank must beat lamp test. An order that got either wrong would light a dark display or hide the lamp test.

Code 15 and code 0 are deliberately placed next to each other. A code 15 in a higher digit must stop suppression even though that digit shows nothing.

The dimmer is measured by counting lit cycles over a full period at duties of 0, 1, 64 and 255. An off-by-one in the comparison would show up as one lit cycle too many or too few.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  typedef logic [SEG_W-1:0] seg_t;  // bit 0 = a ... bit 6 = g

  // Active-high map of lit segments for each code.
  function automatic seg_t glyph_lit(input logic [BCD_W-1:0] code);
    seg_t m;
    case (code)
      4'd0:    m = 7'b0111111;
      4'd1:    m = 7'b0000110;
      4'd2:    m = 7'b1011011;
      4'd3:    m = 7'b1001111;
      4'd4:    m = 7'b1100110;
      4'd5:    m = 7'b1101101;
      4'd6:    m = 7'b1111100;
      4'd7:    m = 7'b0000111;
      4'd8:    m = 7'b1111111;
      4'd9:    m = 7'b1100111;
      4'd10:   m = 7'b1011000;
      4'd11:   m = 7'b1001100;
      4'd12:   m = 7'b1100010;
      4'd13:   m = 7'b1101001;
      4'd14:   m = 7'b1111000;
      default: m = 7'b0000000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/seg_digit_dec.sv
module seg_digit_dec
  import seg_pkg::*;
(
  input  logic [BCD_W-1:0] code,
  input  logic             lamp_test_n,
  input  logic             blank_n,
  input  logic             rb_in_n,
  output seg_t             seg_n,
  output logic             rb_out_n
);
  logic zero_hit;

  always_comb begin
    zero_hit = lamp_test_n & ~rb_in_n & (code == '0);
    rb_out_n = ~zero_hit;
    // Priority: forced blank, then lamp test, then zero suppression.
    if (!blank_n)          seg_n = '1;
    else if (!lamp_test_n) seg_n = '0;
    else if (zero_hit)     seg_n = '1;
    else                   seg_n = ~glyph_lit(code);
  end
endmodule

// File: rtl/seg_pwm_gen.sv
module seg_pwm_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_on
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pwm_on = (cnt_q < duty);
endmodule

// File: rtl/seg_display_top.sv
module seg_display_top
  import seg_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DUTY_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lamp_test_n,
  input  logic                        blank_n,
  input  logic [DUTY_W-1:0]           duty,
  input  logic [NUM_DIGITS*BCD_W-1:0] bcd,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_n,
  output logic [NUM_DIGITS-1:0]       rb_out_n
);
  localparam int MSD = NUM_DIGITS - 1;

  // Reset: asserted at once, released through two flops.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic pwm_on;
  seg_pwm_gen #(.CNT_W(DUTY_W)) pwm_i (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .duty   (duty),
    .pwm_on (pwm_on)
  );

  logic eff_blank_n;
  assign eff_blank_n = blank_n & pwm_on;

  logic [NUM_DIGITS-1:0] rb_in_n;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    if (i == 0) begin : g_lsd
      assign rb_in_n[i] = 1'b1;
    end else if (i == MSD) begin : g_msd
      assign rb_in_n[i] = 1'b0;
    end else begin : g_mid
      assign rb_in_n[i] = rb_out_n[i+1];
    end

    seg_digit_dec dec_i (
      .code        (bcd[i*BCD_W +: BCD_W]),
      .lamp_test_n (lamp_test_n),
      .blank_n     (eff_blank_n),
      .rb_in_n     (rb_in_n[i]),
      .seg_n       (seg_n[i*SEG_W +: SEG_W]),
      .rb_out_n    (rb_out_n[i])
    );
  end
endmodule

// File: rtl/seg_display_chk.sv
module seg_display_chk #(
  parameter int NUM_DIGITS = 4,
  parameter int DUTY_W     = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    lamp_test_n,
  input logic                    blank_n,
  input logic                    pwm_on,
  input logic [DUTY_W-1:0]       duty,
  input logic [NUM_DIGITS*4-1:0] bcd,
  input logic [NUM_DIGITS*7-1:0] seg_n,
  input logic [NUM_DIGITS-1:0]   rb_out_n
);
  p_blank_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (&seg_n));

  p_duty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> (&seg_n));

  p_lamp_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && pwm_on && !lamp_test_n) |-> (seg_n == '0));

  p_lamp_rbo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_test_n |-> (&rb_out_n));

  p_lsd_rbo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_out_n[0]);

  p_lsd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && pwm_on && lamp_test_n && bcd[3:0] == 4'd0)
      |-> (seg_n[6:0] == 7'b1000000));

  for (genvar i = 1; i < NUM_DIGITS; i++) begin : g_sup
    logic rbi_low;
    if (i == NUM_DIGITS - 1) begin : g_top
      assign rbi_low = 1'b1;
    end else begin : g_inner
      assign rbi_low = !rb_out_n[i+1];
    end
    p_zero_sup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lamp_test_n && rbi_low && bcd[i*4 +: 4] == 4'd0)
        |-> (!rb_out_n[i] && (&seg_n[i*7 +: 7])));
    p_nonzero_rbo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bcd[i*4 +: 4] != 4'd0) |-> rb_out_n[i]);
  end
endmodule

bind seg_display_top seg_display_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .DUTY_W     (DUTY_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .lamp_test_n (lamp_test_n),
  .blank_n     (blank_n),
  .pwm_on      (pwm_on),
  .duty        (duty),
  .bcd         (bcd),
  .seg_n       (seg_n),
  .rb_out_n    (rb_out_n)
);

// File: tb/seg_display_tb.sv
module seg_display_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lamp_test_n;
  logic        blank_n;
  logic [7:0]  duty;
  logic [15:0] bcd;
  logic [27:0] seg_n;
  logic [3:0]  rb_out_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_display_top dut_i (
    .clk (clk), .rst_n (rst_n), .lamp_test_n (lamp_test_n),
    .blank_n (blank_n), .duty (duty), .bcd (bcd),
    .seg_n (seg_n), .rb_out_n (rb_out_n)
  );

  // Lit masks from R1/R2, bit 0 = a.
  localparam logic [6:0] LIT [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7C, 7'h07,
    7'h7F, 7'h67, 7'h58, 7'h4C, 7'h62, 7'h69, 7'h78, 7'h00};

  typedef struct packed {
    logic        lt_n;
    logic        bl_n;
    logic [15:0] code;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 16'h0000},  // R6 lone zero
    '{1'b1, 1'b1, 16'h0012},  // R5 leading zeros
    '{1'b1, 1'b1, 16'h1000},  // R6 trailing zeros shown
    '{1'b1, 1'b1, 16'h0102},  // R5 inner zero shown
    '{1'b1, 1'b1, 16'h3456},  // R1
    '{1'b1, 1'b1, 16'h7890},  // R1
    '{1'b1, 1'b1, 16'h89AB},  // R2
    '{1'b1, 1'b1, 16'hCDEF},  // R2
    '{1'b1, 1'b1, 16'h0F00},  // R5 code 15 stops suppression
    '{1'b1, 1'b1, 16'h0007},  // R5
    '{1'b0, 1'b1, 16'h0000},  // R4 lamp test beats suppression
    '{1'b0, 1'b1, 16'h1234},  // R4
    '{1'b1, 1'b0, 16'h8888},  // R3 forced blank
    '{1'b0, 1'b0, 16'h0000}   // R3 blank beats lamp test
  };

  // Bench model of the counter, phase-locked through the outputs.
  logic [7:0] mcnt = 8'd0;
  bit         locked = 1'b0;
  always @(posedge clk) if (locked) mcnt <= mcnt + 8'd1;

  function automatic logic [31:0] model(input vec_t v, input logic on);
    logic [27:0] s;
    logic [3:0]  r;
    logic        rbi;
    logic [3:0]  c;
    for (int i = 3; i >= 0; i--) begin
      c   = v.code[i*4 +: 4];
      rbi = (i == 0) ? 1'b1 : (i == 3) ? 1'b0 : r[i+1];
      r[i] = !(v.lt_n && !rbi && c == 4'd0);
      if (!v.bl_n || !on)              s[i*7 +: 7] = 7'h7F;
      else if (!v.lt_n)                s[i*7 +: 7] = 7'h00;
      else if (!r[i])                  s[i*7 +: 7] = 7'h7F;
      else                             s[i*7 +: 7] = ~LIT[c];
    end
    return {r, s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic count_lit(input logic [7:0] d, output int n);
    duty = d;
    n = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); #1;
      if (seg_n[0] == 1'b0) n++;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; lamp_test_n = 1'b0; blank_n = 1'b1; duty = 8'd1; bcd = 16'h0000;
    // R8: counter held at 0 during reset, so duty 1 stays lit.
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #1;
      check("R8 lit in reset", {4'h0, seg_n}, 32'h0);
    end
    duty = 8'd0;
    @(negedge clk); #1;
    check("R7 duty0 dark in reset", {4'h0, seg_n}, {4'h0, 28'hFFFFFFF});
    duty = 8'd1;
    @(negedge clk); rst_n = 1'b1;
    // Lock phase: last lit sample is count 0, first dark is count 1.
    while (seg_n[0] !== 1'b0) @(negedge clk);
    while (seg_n[0] === 1'b0) @(negedge clk);
    mcnt = 8'd1; locked = 1'b1;

    // Dimming duty counts over a full period.
    count_lit(8'd0,   n); check("R7 duty 0",   n, 0);
    count_lit(8'd1,   n); check("R7 duty 1",   n, 1);
    count_lit(8'd64,  n); check("R7 duty 64",  n, 64);
    count_lit(8'd255, n); check("R7 duty 255", n, 255);

    // Vector table, walked twice at different duty phases.
    duty = 8'd255;
    for (int pass = 0; pass < 2; pass++) begin
      for (int j = 0; j < NV; j++) begin
        @(negedge clk);
        lamp_test_n = VECS[j].lt_n; blank_n = VECS[j].bl_n; bcd = VECS[j].code;
        #1;
        check("R1-table", {rb_out_n, seg_n}, model(VECS[j], mcnt < duty));
      end
      duty = 8'd128;
    end

    // R3: dimming dark phase blanks lamp test too (duty 128, count >= 128).
    lamp_test_n = 1'b0; blank_n = 1'b1; bcd = 16'h0000;
    while (mcnt != 8'd200) @(negedge clk);
    #1;
    check("R3 pwm dark beats lamp test", {4'h0, seg_n}, {4'h0, 28'hFFFFFFF});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule